// File: doc/BRIEF.md
# Frequency and Voltage Change Sequencer

This block is the processor-side controller that moves the core to a new operating point. Software writes one 64-bit control word. The word carries a target frequency code, a target voltage code, two enable bits, an arm bit and a 20-bit settle count. The sequencer then tears down the bus link to its partner. It announces the change with a special bus cycle and waits for the partner to drop the link. It then presents the new codes to the voltage regulator and the PLL.

While the new codes are applied, the block waits out the settle count, one count per reference clock. The block's clock is taken as the reference clock. When the count runs out, the block asks for a fresh initialization stream with a one-cycle ready pulse. When the partner reports that the stream is done, the block rebuilds the link and issues a Connect special cycle.

The current codes are visible at all times on the code outputs, and a busy flag covers the whole exchange. PLL lock time is assumed to be covered by the programmed count.

Top module: `perf_shift_seq`

## Requirements
- R1: A write made while idle starts a change if bit 20 is 1 and bits [51:32] are non-zero. The announce cycle appears in the next cycle. A write with bits [51:32] equal to zero is ignored.
- R2: A write with bit 20 equal to 0 is ignored. Any write made while busy is high is ignored, including one made in the cycle of the Connect cycle.
- R3: The announce cycle lasts one cycle with cyc_valid high. In that cycle cyc_data[31:0] is 32'h0007_0002 and cyc_data[36:32] is the frequency code being sent.
- R4: After the announce cycle, proc_rdy stays high until link_conn is sampled low. It then goes low and stays low while the block waits for fwd_rst to be sampled high.
- R5: In the cycle after fwd_rst is sampled high, soft_vid and pll_code take their new values. proc_rdy then stays low for exactly N cycles, where N is the value written to bits [51:32].
- R6: After those N cycles, proc_rdy is high for exactly one cycle. It is then low until init_done is sampled high. Changes on fwd_rst in this wait have no effect.
- R7: After init_done, proc_rdy is high until fwd_rst is sampled low. A one-cycle Connect cycle then follows, with cyc_data[31:0] equal to CONN_CODE (default 32'h0007_0003) and cyc_data[36:32] equal to 0.
- R8: The target frequency is bits [4:0] when bit 16 is 1. When bit 16 is 0, the current pll_code is sent and kept. The target voltage is bits [12:8] when bit 17 is 1. When bit 17 is 0, soft_vid is kept.
- R9: busy is high from the cycle after the starting write through the Connect cycle, and low in the cycle after it.
- R10: During and after reset, proc_rdy is 1, busy is 0 and cyc_valid is 0. soft_vid is RST_VOLT (default 10) and pll_code is RST_FREQ (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 64 | Control word |
| link_conn | input | 1 | Partner keeps the link connected |
| fwd_rst | input | 1 | Partner holds the forward clocks in reset |
| init_done | input | 1 | Initialization stream fully received |
| cyc_valid | output | 1 | Special bus cycle issued this cycle |
| cyc_data | output | 37 | Special cycle data |
| proc_rdy | output | 1 | Processor ready toward the partner |
| soft_vid | output | 5 | Voltage code for the regulator |
| pll_code | output | 5 | Frequency code for the PLL |
| busy | output | 1 | Change in progress |

## Verification
Two functions can fall in the same cycle: the closing Connect cycle, and a new control write that would start the next change. The bench drives a valid arming write in exactly the cycle where the Connect cycle is observed. It expects the write to be dropped: busy must be low in the next cycle and no announce cycle may follow. A second overlap is a low pulse on fwd_rst while the block waits for init_done. The reference model expects this pulse to be ignored, and it compares every output on every clock.

// File: rtl/perf_shift_seq.sv
module perf_shift_seq #(
  parameter int          CODE_W    = 5,
  parameter int          CNT_W     = 20,
  parameter logic [4:0]  RST_FREQ  = 5'd4,
  parameter logic [4:0]  RST_VOLT  = 5'd10,
  parameter logic [31:0] CHG_CODE  = 32'h0007_0002,
  parameter logic [31:0] CONN_CODE = 32'h0007_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [63:0]       ctl_wdata,
  input  logic              link_conn,
  input  logic              fwd_rst,
  input  logic              init_done,
  output logic              cyc_valid,
  output logic [36:0]       cyc_data,
  output logic              proc_rdy,
  output logic [CODE_W-1:0] soft_vid,
  output logic [CODE_W-1:0] pll_code,
  output logic              busy
);
  localparam int F_LO   = 0;
  localparam int V_LO   = 8;
  localparam int F_EN   = 16;
  localparam int V_EN   = 17;
  localparam int ARM    = 20;
  localparam int CNT_LO = 32;

  typedef enum logic [3:0] {
    S_IDLE, S_ANN, S_WDISC, S_WFWD, S_COUNT, S_PULSE, S_WSIP, S_RECON, S_CONN
  } st_t;

  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CODE_W-1:0] tgt_f, tgt_v, pll_q, vid_q;

  wire [CNT_W-1:0]  wr_cnt = ctl_wdata[CNT_LO +: CNT_W];
  wire              go     = ctl_we && ctl_wdata[ARM] && (wr_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      tgt_f <= RST_FREQ;
      tgt_v <= RST_VOLT;
      pll_q <= RST_FREQ;
      vid_q <= RST_VOLT;
    end else begin
      case (st_q)
        S_IDLE: if (go) begin
          st_q  <= S_ANN;
          cnt_q <= wr_cnt;
          tgt_f <= ctl_wdata[F_EN] ? ctl_wdata[F_LO +: CODE_W] : pll_q;
          tgt_v <= ctl_wdata[V_EN] ? ctl_wdata[V_LO +: CODE_W] : vid_q;
        end
        S_ANN:   st_q <= S_WDISC;
        S_WDISC: if (!link_conn) st_q <= S_WFWD;
        S_WFWD:  if (fwd_rst) begin
          st_q  <= S_COUNT;
          pll_q <= tgt_f;
          vid_q <= tgt_v;
        end
        S_COUNT: if (cnt_q == CNT_W'(1)) st_q <= S_PULSE;
                 else cnt_q <= cnt_q - CNT_W'(1);
        S_PULSE: st_q <= S_WSIP;
        S_WSIP:  if (init_done) st_q <= S_RECON;
        S_RECON: if (!fwd_rst) st_q <= S_CONN;
        S_CONN:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cyc_valid = (st_q == S_ANN) || (st_q == S_CONN);
  assign cyc_data  = (st_q == S_ANN)  ? {tgt_f, CHG_CODE} :
                     (st_q == S_CONN) ? {{CODE_W{1'b0}}, CONN_CODE} : '0;
  assign proc_rdy  = (st_q == S_IDLE) || (st_q == S_ANN) || (st_q == S_WDISC) ||
                     (st_q == S_PULSE) || (st_q == S_RECON) || (st_q == S_CONN);
  assign busy      = (st_q != S_IDLE);
  assign soft_vid  = vid_q;
  assign pll_code  = pll_q;
endmodule

// File: rtl/perf_shift_seq_chk.sv
module perf_shift_seq_chk #(
  parameter int          CNT_W     = 20,
  parameter logic [31:0] CHG_CODE  = 32'h0007_0002,
  parameter logic [31:0] CONN_CODE = 32'h0007_0003
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             proc_rdy,
  input logic             cyc_valid,
  input logic [36:0]      cyc_data,
  input logic [4:0]       soft_vid,
  input logic [4:0]       pll_code,
  input logic [3:0]       st,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [3:0] ST_IDLE  = 4'd0;
  localparam logic [3:0] ST_COUNT = 4'd4;
  localparam logic [3:0] ST_PULSE = 4'd5;

  p_special_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  p_start_announce_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cyc_valid && cyc_data[31:0] == CHG_CODE));

  p_idle_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> ($stable(soft_vid) && $stable(pll_code)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COUNT && cnt != CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PULSE && proc_rdy) |=> !proc_rdy);

  p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_data[31:0] == CONN_CODE) |=> !busy);
endmodule

bind perf_shift_seq perf_shift_seq_chk #(
  .CNT_W(CNT_W), .CHG_CODE(CHG_CODE), .CONN_CODE(CONN_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .proc_rdy(proc_rdy),
  .cyc_valid(cyc_valid), .cyc_data(cyc_data), .soft_vid(soft_vid),
  .pll_code(pll_code), .st(st_q), .cnt(cnt_q)
);

// File: tb/perf_shift_seq_tb.sv
`timescale 1ns/1ps
module perf_shift_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, link_conn = 1'b1, fwd_rst = 1'b0, init_done = 1'b0;
  logic [63:0] ctl_wdata = '0;
  logic cyc_valid, proc_rdy, busy;
  logic [36:0] cyc_data;
  logic [4:0] soft_vid, pll_code;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  perf_shift_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .link_conn(link_conn), .fwd_rst(fwd_rst), .init_done(init_done),
    .cyc_valid(cyc_valid), .cyc_data(cyc_data), .proc_rdy(proc_rdy),
    .soft_vid(soft_vid), .pll_code(pll_code), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase number plus remaining count
  int m_ph = 0, m_left = 0;
  logic [4:0] m_f = 5'd4, m_v = 5'd10, m_tf = 5'd4, m_tv = 5'd10;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_f = 5'd4; m_v = 5'd10; m_tf = 5'd4; m_tv = 5'd10;
    end else begin
      case (m_ph)
        0: if (ctl_we && ctl_wdata[20] && ctl_wdata[51:32] != 0) begin
             m_ph = 1; m_left = int'(ctl_wdata[51:32]);
             m_tf = ctl_wdata[16] ? ctl_wdata[4:0] : m_f;
             m_tv = ctl_wdata[17] ? ctl_wdata[12:8] : m_v;
           end
        1: m_ph = 2;
        2: if (!link_conn) m_ph = 3;
        3: if (fwd_rst) begin m_ph = 4; m_f = m_tf; m_v = m_tv; end
        4: begin m_left--; if (m_left == 0) m_ph = 5; end
        5: m_ph = 6;
        6: if (init_done) m_ph = 7;
        7: if (!fwd_rst) m_ph = 8;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_cv, e_rdy;
      logic [36:0] e_cd;
      e_cv  = (m_ph == 1) || (m_ph == 8);
      e_cd  = (m_ph == 1) ? {m_tf, 32'h0007_0002} : (m_ph == 8) ? {5'd0, 32'h0007_0003} : '0;
      e_rdy = (m_ph == 0) || (m_ph == 1) || (m_ph == 2) || (m_ph == 5) || (m_ph == 7) || (m_ph == 8);
      chk(cyc_valid == e_cv && (!e_cv || cyc_data == e_cd), "R3/R7 model cycle", {cyc_valid, cyc_data}, {e_cv, e_cd});
      chk(proc_rdy == e_rdy, "R4/R6 model ready", proc_rdy, e_rdy);
      chk(soft_vid == m_v && pll_code == m_f, "R5/R8 model codes", {soft_vid, pll_code}, {m_v, m_f});
      chk(busy == (m_ph != 0), "R9 model busy", busy, m_ph != 0);
    end
  end

  function automatic logic [63:0] mk(int tmo, bit arm, bit ven, bit fen, logic [4:0] v, logic [4:0] f);
    logic [63:0] w = '0;
    w[51:32] = tmo[19:0]; w[20] = arm; w[17] = ven; w[16] = fen; w[12:8] = v; w[4:0] = f;
    return w;
  endfunction

  task automatic wr(input logic [63:0] w);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  logic [36:0] last_ann;

  task automatic partner(input int tmo, input bit inject);
    int k;
    while (!(cyc_valid && cyc_data[31:0] == 32'h0007_0002)) @(negedge clk);
    last_ann = cyc_data;
    @(negedge clk);
    chk(proc_rdy == 1'b1, "R4 ready held before drop", proc_rdy, 1);
    link_conn = 1'b0;
    while (proc_rdy) @(negedge clk);
    @(negedge clk);
    chk(proc_rdy == 1'b0, "R4 ready low awaiting fwd_rst", proc_rdy, 0);
    fwd_rst = 1'b1;
    @(negedge clk);
    k = 0;
    while (!proc_rdy) begin k++; @(negedge clk); end
    chk(k == tmo, "R5 settle length", k, tmo);
    @(negedge clk);
    chk(proc_rdy == 1'b0, "R6 ready pulse one cycle", proc_rdy, 0);
    fwd_rst = 1'b0;
    @(negedge clk); fwd_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(proc_rdy == 1'b0, "R6 fwd_rst pulse ignored", proc_rdy, 0);
    init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    chk(proc_rdy == 1'b1, "R7 ready after stream", proc_rdy, 1);
    fwd_rst = 1'b0;
    while (!(cyc_valid && cyc_data[31:0] == 32'h0007_0003)) @(negedge clk);
    chk(cyc_data[36:32] == 5'd0, "R7 connect upper bits", cyc_data[36:32], 0);
    if (inject) begin ctl_we = 1'b1; ctl_wdata = mk(3, 1, 1, 1, 5'd1, 5'd1); end
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
    chk(busy == 1'b0, "R9 busy low after connect", busy, 0);
    link_conn = 1'b1;
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(busy == 1'b0 && cyc_valid == 1'b0, tag, {busy, cyc_valid}, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", busy, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(proc_rdy && !busy && !cyc_valid, "R10 reset flags", {proc_rdy, busy, cyc_valid}, 3'b100);
    chk(soft_vid == 5'd10 && pll_code == 5'd4, "R10 reset codes", {soft_vid, pll_code}, {5'd10, 5'd4});

    wr(mk(5, 1, 1, 1, 5'd7, 5'd9));
    partner(5, 0);
    chk(last_ann[36:32] == 5'd9, "R3 sent frequency", last_ann[36:32], 9);
    chk(pll_code == 5'd9 && soft_vid == 5'd7, "R5 new codes", {soft_vid, pll_code}, {5'd7, 5'd9});

    wr(mk(3, 1, 1, 0, 5'd12, 5'd20));
    partner(3, 0);
    chk(last_ann[36:32] == 5'd9, "R8 voltage-only sends current freq", last_ann[36:32], 9);
    chk(pll_code == 5'd9 && soft_vid == 5'd12, "R8 voltage-only codes", {soft_vid, pll_code}, {5'd12, 5'd9});

    wr(mk(4, 0, 1, 1, 5'd2, 5'd2));
    quiet("R2 unarmed write ignored");

    wr(mk(0, 1, 1, 1, 5'd2, 5'd2));
    quiet("R1 zero count ignored");

    wr(mk(1, 1, 0, 1, 5'd30, 5'd3));
    partner(1, 1);
    quiet("R2 write in connect cycle ignored");
    chk(pll_code == 5'd3 && soft_vid == 5'd12, "R8 frequency-only codes", {soft_vid, pll_code}, {5'd12, 5'd3});

    finish_run();
  end
endmodule